// File: doc/BRIEF.md
# Indirect Memory Access Window

This bridge lets a host reach a large word-organised internal memory through a handful of small registers. The host loads a target byte address into an address register. It then reads or writes a data window with 8-, 16- or 32-bit accesses. Each window access becomes a single memory transaction at the word that the address register selects. The address never advances on its own, so repeated window accesses keep hitting the same word.

Two lookup helpers sit beside the window. The first table helper reads a 32-bit pointer at the first-table base plus the offset held in the address register, then performs the host's access at that pointer. The second table helper reads a two-word descriptor (a data pointer, then a word holding an element count in its upper half and an element size in its lower half). It returns the product count times size when that fits a host-programmed limit, and signals an error when it does not.

A single state machine sequences all of this. Its states are IDLE (the only state that accepts a request), WIN (window memory access), TPTR (first-table pointer fetch), TACC (access at the fetched pointer), DPTR (descriptor pointer fetch), DINFO (descriptor count/size fetch) and RESP (one-cycle response). The transitions are: IDLE→RESP for register accesses, IDLE→WIN→RESP, IDLE→TPTR→TACC→RESP, IDLE→DPTR→DINFO→RESP, and RESP→IDLE. Every memory state waits there until `mem_ready` is high.

Top module: `iwin_bridge`

## Requirements
- R1: After reset `host_ready` is 1, `host_ack` and `mem_valid` are 0, and a read of the address register (host offset 0x00) returns 0.
- R2: A 32-bit access at host offset 0x04 reads or writes the whole memory word at byte address `addr_reg` with its two low bits ignored (`mem_addr = addr_reg[31:2]`). The address register is written and read at offset 0x00.
- R3: An 8-bit window access at host offset 0x04+k (k = 0..3) uses byte lane k only, with lane k being bits 8k+7..8k. A write takes `host_wdata[7:0]` and leaves the other lanes untouched. A read returns the byte zero-extended.
- R4: A 16-bit window access uses lanes 0–1 when host offset bit 1 is 0 and lanes 2–3 when it is 1, in little-endian order. A read returns the half-word zero-extended. (`host_size` encoding: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit.)
- R5: Repeated window accesses never change the address. Consecutive writes and reads all target the same word.
- R6: While a memory request is outstanding, `host_ready` stays 0, no `host_ack` is given and the memory request stays stable. A window access is acknowledged exactly 2 + L cycles after acceptance, where L is the number of cycles `mem_ready` is held off.
- R7: An access at host offset 0x10 reads a pointer at byte address `t1_base + addr_reg` (with `t1_base` at offset 0x08), then performs the access at that pointer. An 8-bit read at that pointer returns byte lane `ptr[1:0]`.
- R8: A read at host offset 0x14 reads a descriptor at `t2_base + addr_reg` (with `t2_base` at offset 0x0C): a pointer word, then an info word {count[31:16], size[15:0]}. When count×size ≤ limit, the read returns count×size with `host_err` = 0, and the pointer becomes readable at offset 0x18. A write at 0x14 sets the limit.
- R9: When count×size exceeds the limit, the response carries `host_err` = 1 and data 0, and the pointer at offset 0x18 keeps its previous value. A product equal to the limit succeeds.
- R10: Every accepted request receives exactly one `host_ack`, one cycle long. `host_err` is only ever high together with `host_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request, accepted when `host_ready` is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Host register offset |
| host_size | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| host_wdata | input | 32 | Write data, right-aligned |
| host_ready | output | 1 | Bridge idle and able to accept a request |
| host_ack | output | 1 | One-cycle response strobe |
| host_rdata | output | 32 | Read data, right-aligned, valid with `host_ack` |
| host_err | output | 1 | Descriptor length error, valid with `host_ack` |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 30 | Memory word address |
| mem_strb | output | 4 | Byte strobes for writes |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_ready | input | 1 | Memory accepts the request; read data is valid in this cycle |
| mem_rdata | input | 32 | Memory read data |

## Verification
A wrong lane select or a wrong strobe shows up as a corrupted neighbouring byte in the next 32-bit readback, one transaction later. A stuck or mis-sequenced state shows up at once as a missing acknowledgement or an acknowledgement that comes at the wrong cycle count. The bench counts that count exactly for every memory latency it sweeps. A wrong pointer or descriptor address shows up as wrong data or length in the same response. Stale error or pointer state shows up at the next lookup with the opposite outcome and at the pointer readback.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
    localparam int DW = 32;
    localparam int NB = DW / 8;

    typedef enum logic [1:0] {
        SZ_B  = 2'd0,
        SZ_H  = 2'd1,
        SZ_W  = 2'd2,
        SZ_W2 = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WIN,
        ST_TPTR,
        ST_TACC,
        ST_DPTR,
        ST_DINFO,
        ST_RESP
    } state_e;

    // host register word index, host_addr[4:2]
    localparam logic [2:0] RG_ADDR = 3'd0;
    localparam logic [2:0] RG_WIN  = 3'd1;
    localparam logic [2:0] RG_T1B  = 3'd2;
    localparam logic [2:0] RG_T2B  = 3'd3;
    localparam logic [2:0] RG_T1   = 3'd4;
    localparam logic [2:0] RG_T2   = 3'd5;
    localparam logic [2:0] RG_T2P  = 3'd6;
endpackage

// File: rtl/iwin_lanes.sv
module iwin_lanes
    import iwin_pkg::*;
(
    input  logic [1:0]    acc_size,
    input  logic [1:0]    acc_lane,
    input  logic [DW-1:0] hwdata,
    input  logic [DW-1:0] mrdata,
    output logic [NB-1:0] strb,
    output logic [DW-1:0] mwdata,
    output logic [DW-1:0] hrdata
);
    logic [DW-1:0] shifted;

    assign shifted = mrdata >> {acc_lane, 3'b000};

    always_comb begin
        unique case (size_e'(acc_size))
            SZ_B: begin
                strb   = NB'(1) << acc_lane;
                mwdata = {NB{hwdata[7:0]}};
                hrdata = {{(DW-8){1'b0}}, shifted[7:0]};
            end
            SZ_H: begin
                strb   = acc_lane[1] ? 4'b1100 : 4'b0011;
                mwdata = {2{hwdata[15:0]}};
                hrdata = acc_lane[1] ? {16'h0, mrdata[31:16]}
                                     : {16'h0, mrdata[15:0]};
            end
            default: begin
                strb   = '1;
                mwdata = hwdata;
                hrdata = mrdata;
            end
        endcase
    end
endmodule

// File: rtl/iwin_ctrl.sv
module iwin_ctrl
    import iwin_pkg::*;
#(
    parameter int AW  = 32,
    parameter int HOW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_req,
    input  logic           host_we,
    input  logic [HOW-1:0] host_addr,
    input  logic [1:0]     host_size,
    input  logic [DW-1:0]  host_wdata,
    output logic           host_ready,
    output logic           host_ack,
    output logic [DW-1:0]  host_rdata,
    output logic           host_err,
    output logic           mem_valid,
    output logic           mem_we,
    output logic [AW-3:0]  mem_addr,
    input  logic           mem_ready,
    input  logic [DW-1:0]  mem_rdata,
    output logic [1:0]     acc_size,
    output logic [1:0]     acc_lane,
    output logic [DW-1:0]  acc_wdata,
    input  logic [DW-1:0]  lane_rdata
);
    localparam int HW = DW / 2;

    state_e        state_q, state_d;
    logic [AW-1:0] areg_q, t1b_q, t2b_q, maddr_q, ptr_q, t2p_q;
    logic [DW-1:0] lim_q, resp_q, wdata_q;
    logic          we_q, err_q;
    logic [1:0]    size_q, lane_q;
    logic [DW-1:0] total;
    logic [2:0]    rsel;
    logic          hs;

    assign rsel  = host_addr[4:2];
    assign hs    = mem_valid && mem_ready;
    assign total = DW'(mem_rdata[DW-1:HW]) * DW'(mem_rdata[HW-1:0]);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (host_req) begin
                unique case (rsel)
                    RG_WIN:  state_d = ST_WIN;
                    RG_T1:   state_d = ST_TPTR;
                    RG_T2:   state_d = host_we ? ST_RESP : ST_DPTR;
                    default: state_d = ST_RESP;
                endcase
            end
            ST_WIN:   if (mem_ready) state_d = ST_RESP;
            ST_TPTR:  if (mem_ready) state_d = ST_TACC;
            ST_TACC:  if (mem_ready) state_d = ST_RESP;
            ST_DPTR:  if (mem_ready) state_d = ST_DINFO;
            ST_DINFO: if (mem_ready) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            areg_q  <= '0;
            t1b_q   <= '0;
            t2b_q   <= '0;
            maddr_q <= '0;
            ptr_q   <= '0;
            t2p_q   <= '0;
            lim_q   <= '0;
            resp_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            err_q   <= 1'b0;
            size_q  <= SZ_W;
            lane_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (host_req) begin
                    we_q    <= host_we;
                    size_q  <= host_size;
                    lane_q  <= host_addr[1:0];
                    wdata_q <= host_wdata;
                    err_q   <= 1'b0;
                    resp_q  <= '0;
                    unique case (rsel)
                        RG_ADDR: if (host_we) areg_q <= host_wdata;
                                 else         resp_q <= areg_q;
                        RG_T1B:  if (host_we) t1b_q <= host_wdata;
                                 else         resp_q <= t1b_q;
                        RG_T2B:  if (host_we) t2b_q <= host_wdata;
                                 else         resp_q <= t2b_q;
                        RG_WIN:  maddr_q <= areg_q;
                        RG_T1:   maddr_q <= t1b_q + areg_q;
                        RG_T2:   if (host_we) lim_q <= host_wdata;
                                 else         maddr_q <= t2b_q + areg_q;
                        RG_T2P:  resp_q <= t2p_q;
                        default: ;
                    endcase
                end
                ST_WIN, ST_TACC: if (mem_ready) resp_q <= lane_rdata;
                ST_TPTR: if (mem_ready) begin
                    maddr_q <= mem_rdata;
                    lane_q  <= mem_rdata[1:0];
                end
                ST_DPTR: if (mem_ready) begin
                    ptr_q   <= mem_rdata;
                    maddr_q <= maddr_q + AW'(4);
                end
                ST_DINFO: if (mem_ready) begin
                    if (total > lim_q) begin
                        err_q  <= 1'b1;
                        resp_q <= '0;
                    end else begin
                        resp_q <= total;
                        t2p_q  <= ptr_q;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        host_ready = (state_q == ST_IDLE);
        host_ack   = (state_q == ST_RESP);
        host_rdata = host_ack ? resp_q : '0;
        host_err   = host_ack && err_q;
        mem_valid  = (state_q inside {ST_WIN, ST_TPTR, ST_TACC, ST_DPTR, ST_DINFO});
        mem_we     = we_q && (state_q inside {ST_WIN, ST_TACC});
        mem_addr   = maddr_q[AW-1:2];
        acc_size   = (state_q inside {ST_WIN, ST_TACC}) ? size_q : SZ_W;
        acc_lane   = lane_q;
        acc_wdata  = wdata_q;
    end

    // R6: an outstanding memory request is held unchanged until accepted
    p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));
    // R6: host is stalled while memory is busy
    p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !host_ready && !host_ack);
    // R10: acknowledge is a single-cycle pulse
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
    // R10: an accepted request leaves idle
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && host_ready |=> !host_ready);
    // R10: error qualifies an acknowledge only
    p_err_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> host_ack);
    // R9: an error response carries no data
    p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> host_rdata == '0);
    // R1: memory idle right after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !mem_valid && host_ready);
    // R7: the pointer access follows a completed pointer fetch
    p_tacc_after_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_TPTR && hs |=> mem_valid && mem_addr == $past(mem_rdata[AW-1:2]));
endmodule

// File: rtl/iwin_bridge.sv
module iwin_bridge
    import iwin_pkg::*;
#(
    parameter int AW  = 32,
    parameter int HOW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_req,
    input  logic           host_we,
    input  logic [HOW-1:0] host_addr,
    input  logic [1:0]     host_size,
    input  logic [31:0]    host_wdata,
    output logic           host_ready,
    output logic           host_ack,
    output logic [31:0]    host_rdata,
    output logic           host_err,
    output logic           mem_valid,
    output logic           mem_we,
    output logic [AW-3:0]  mem_addr,
    output logic [3:0]     mem_strb,
    output logic [31:0]    mem_wdata,
    input  logic           mem_ready,
    input  logic [31:0]    mem_rdata
);
    logic [1:0]    acc_size, acc_lane;
    logic [DW-1:0] acc_wdata, lane_rdata;

    iwin_ctrl #(.AW(AW), .HOW(HOW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_size  (host_size),
        .host_wdata (host_wdata),
        .host_ready (host_ready),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .host_err   (host_err),
        .mem_valid  (mem_valid),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .acc_size   (acc_size),
        .acc_lane   (acc_lane),
        .acc_wdata  (acc_wdata),
        .lane_rdata (lane_rdata)
    );

    iwin_lanes u_lanes (
        .acc_size (acc_size),
        .acc_lane (acc_lane),
        .hwdata   (acc_wdata),
        .mrdata   (mem_rdata),
        .strb     (mem_strb),
        .mwdata   (mem_wdata),
        .hrdata   (lane_rdata)
    );

    // R3: a byte write drives exactly one strobe
    p_byte_strb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we && acc_size == SZ_B |-> $countones(mem_strb) == 1);
    // R4: a half-word write drives a lane pair
    p_half_strb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we && acc_size == SZ_H |-> mem_strb == 4'b0011 || mem_strb == 4'b1100);
endmodule

// File: tb/iwin_bridge_tb.sv
module iwin_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready, host_ack, host_err;
    logic [31:0] host_rdata;
    logic        mem_valid, mem_we, mem_ready;
    logic [29:0] mem_addr;
    logic [3:0]  mem_strb;
    logic [31:0] mem_wdata, mem_rdata;

    int checks = 0, fails = 0, lat = 0, wcnt = 0;
    bit done = 0;
    logic [31:0] mem [256];

    always #5 clk = ~clk;

    iwin_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_ack(host_ack), .host_rdata(host_rdata),
        .host_err(host_err), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_strb(mem_strb), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    assign mem_ready = mem_valid && (wcnt == lat);
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= '0;
        end else if (mem_valid && mem_ready) begin
            wcnt <= 0;
            if (mem_we)
                for (int b = 0; b < 4; b++)
                    if (mem_strb[b]) mem[mem_addr[7:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end else if (mem_valid) begin
            wcnt <= wcnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input bit we, input logic [4:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd, output bit e, output int n);
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        n = 1;
        while (!host_ack && n < 100) begin
            @(negedge clk);
            n++;
        end
        rd = host_rdata;
        e = host_err;
    endtask

    task automatic wr(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] wd);
        logic [31:0] rd; bit e; int n;
        op(1'b1, a, sz, wd, rd, e, n);
    endtask

    task automatic rdv(input logic [4:0] a, input logic [1:0] sz, output logic [31:0] rd);
        bit e; int n;
        op(1'b0, a, sz, 32'h0, rd, e, n);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd, exp, w;
        bit e;
        int n;
        repeat (3) @(posedge clk);
        #1;
        chk(host_ready && !host_ack && !mem_valid, "R1 reset outputs",
            {29'h0, host_ready, host_ack, mem_valid}, 32'h4);
        rst_n = 1'b1;
        rdv(5'h00, 2'd2, rd);
        chk(rd == 32'h0, "R1 addr reg reset", rd, 32'h0);

        for (int l = 0; l < 4; l++) begin
            lat = l;
            // R2: word access, low address bits ignored
            wr(5'h00, 2'd2, 32'h40 + l * 16 + l);
            w = 32'hC0DE_0000 + l * 32'h0101;
            wr(5'h04, 2'd2, w);
            wr(5'h00, 2'd2, 32'h40 + l * 16 + 3 - l);
            rdv(5'h04, 2'd2, rd);
            chk(rd == w, "R2 word readback", rd, w);
            // R3: byte lanes
            wr(5'h04, 2'd2, 32'h0);
            exp = 32'h0;
            for (int k = 0; k < 4; k++) begin
                wr(5'h04 + 5'(k), 2'd0, 32'hFFFF_FF00 | (32'hA0 + l * 4 + k));
                exp = exp | ((32'hA0 + l * 4 + k) << (8 * k));
                rdv(5'h04, 2'd2, rd);
                chk(rd == exp, "R3 byte write lane", rd, exp);
            end
            for (int k = 0; k < 4; k++) begin
                rdv(5'h04 + 5'(k), 2'd0, rd);
                chk(rd == ((exp >> (8 * k)) & 32'hFF), "R3 byte read lane", rd, (exp >> (8 * k)) & 32'hFF);
            end
            // R4: half-word lanes
            wr(5'h06, 2'd1, 32'hDEAD_1234 + l);
            exp = {16'h1234 + 16'(l), exp[15:0]};
            rdv(5'h04, 2'd2, rd);
            chk(rd == exp, "R4 upper half write", rd, exp);
            wr(5'h05, 2'd1, 32'h0000_5678);
            exp = {exp[31:16], 16'h5678};
            rdv(5'h04, 2'd2, rd);
            chk(rd == exp, "R4 lower half via bit1=0", rd, exp);
            rdv(5'h06, 2'd1, rd);
            chk(rd == {16'h0, exp[31:16]}, "R4 half read", rd, {16'h0, exp[31:16]});
            // R5: no auto-increment
            wr(5'h04, 2'd2, 32'h1111_1111);
            wr(5'h04, 2'd2, 32'h2222_2222 + l);
            rdv(5'h04, 2'd2, rd);
            rdv(5'h04, 2'd2, rd);
            chk(rd == 32'h2222_2222 + l, "R5 same word repeated", rd, 32'h2222_2222 + l);
            wr(5'h00, 2'd2, 32'h44 + l * 16);
            rdv(5'h04, 2'd2, rd);
            chk(rd == 32'h0, "R5 neighbour word untouched", rd, 32'h0);
            // R6: stall timing
            op(1'b0, 5'h04, 2'd2, 32'h0, rd, e, n);
            chk(n == l + 2, "R6 window ack cycle", n, l + 2);
        end

        // R7: first table
        lat = 1;
        wr(5'h00, 2'd2, 32'h108); wr(5'h04, 2'd2, 32'h205);
        wr(5'h00, 2'd2, 32'h204); wr(5'h04, 2'd2, 32'h4433_2211);
        wr(5'h08, 2'd2, 32'h100);
        wr(5'h00, 2'd2, 32'h8);
        rdv(5'h10, 2'd0, rd);
        chk(rd == 32'h22, "R7 byte via pointer", rd, 32'h22);
        op(1'b0, 5'h10, 2'd2, 32'h0, rd, e, n);
        chk(rd == 32'h4433_2211, "R7 word via pointer", rd, 32'h4433_2211);
        chk(n == 2 * 1 + 3, "R6 table ack cycle", n, 5);
        wr(5'h10, 2'd2, 32'h9988_7766);
        wr(5'h00, 2'd2, 32'h204);
        rdv(5'h04, 2'd2, rd);
        chk(rd == 32'h9988_7766, "R7 write via pointer", rd, 32'h9988_7766);

        // R8/R9: second table
        wr(5'h0C, 2'd2, 32'h300);
        wr(5'h14, 2'd2, 32'd15);
        wr(5'h00, 2'd2, 32'h300); wr(5'h04, 2'd2, 32'h280);
        wr(5'h00, 2'd2, 32'h304); wr(5'h04, 2'd2, {16'd3, 16'd5});
        wr(5'h00, 2'd2, 32'h0);
        op(1'b0, 5'h14, 2'd2, 32'h0, rd, e, n);
        chk(rd == 32'd15 && !e, "R9 product equals limit", rd, 32'd15);
        rdv(5'h18, 2'd2, rd);
        chk(rd == 32'h280, "R8 pointer readback", rd, 32'h280);
        wr(5'h14, 2'd2, 32'd14);
        wr(5'h00, 2'd2, 32'h300); wr(5'h04, 2'd2, 32'h2C0);
        wr(5'h00, 2'd2, 32'h0);
        op(1'b0, 5'h14, 2'd2, 32'h0, rd, e, n);
        chk(e && rd == 32'h0, "R9 overflow error", {e, rd[30:0]}, 32'h8000_0000);
        rdv(5'h18, 2'd2, rd);
        chk(rd == 32'h280, "R9 pointer kept", rd, 32'h280);
        wr(5'h14, 2'd2, 32'd60000);
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 3; s++) begin
                logic [31:0] cv, sv, tot;
                cv = 32'(c * 85);
                sv = (s == 0) ? 32'd0 : (s == 1) ? 32'd4 : 32'd300;
                tot = cv * sv;
                wr(5'h00, 2'd2, 32'h304); wr(5'h04, 2'd2, {cv[15:0], sv[15:0]});
                wr(5'h00, 2'd2, 32'h0);
                op(1'b0, 5'h14, 2'd2, 32'h0, rd, e, n);
                if (tot > 32'd60000)
                    chk(e && rd == 0, "R9 sweep error", rd, 32'h0);
                else
                    chk(!e && rd == tot, "R8 sweep length", rd, tot);
            end
        end
        // R10: single ack per request
        op(1'b0, 5'h00, 2'd2, 32'h0, rd, e, n);
        @(negedge clk);
        chk(!host_ack && host_ready, "R10 single ack", {31'h0, host_ack}, 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule